// File: doc/BRIEF.md
# Interrupt and Subroutine Stack Sequencer

This block carries out the automatic stack traffic that a small 8-bit processor performs when it takes an interrupt, calls a subroutine, or returns from either one. It holds an 8-bit stack pointer and forms each 16-bit stack address from two parts. The high byte comes from a page-select input, which is captured when the command starts. The low byte is the stack pointer. The block drives a synchronous single-port memory with address, write data and write enable, and the memory returns read data one clock after the address. Each transfer takes one clock.

A command is given by a one-cycle `go` pulse together with a 2-bit operation code. For the two entry operations the block stores the program counter bytes, and for an interrupt also the status byte. For a software break, bit 4 of the stored status is forced to 1. The two return operations read the saved bytes back and present the restored program counter and, after a return from interrupt, the restored status byte. `busy` covers the whole operation and `fin` pulses once when the operation ends. Opcode decoding and vector fetch belong to the surrounding processor.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` is 0xFF, `busy`, `fin` and `mem_we` are 0, and `pc_rest` and `st_rest` are 0.
- R2: Operation code 2'b00 (interrupt entry) writes three bytes: the program counter high byte at {page, S}, then the low byte at {page, S-1}, then the status byte at {page, S-2}. Here S is the pointer at the start, and the pointer ends at S-3.
- R3: In an interrupt entry, bit 4 of the stored status byte equals `sw_brk`. The other seven bits equal `st_in`.
- R4: Operation code 2'b01 (subroutine call) writes only two bytes: the program counter high byte at {page, S} and then the low byte at {page, S-1}. The pointer ends at S-2, and no status byte is written.
- R5: Operation code 2'b10 (return from interrupt) writes nothing. It reads {page, S+1} into the status byte, {page, S+2} into the program counter low byte and {page, S+3} into the high byte, and the pointer ends at S+3.
- R6: Operation code 2'b11 (return from subroutine) writes nothing. It reads {page, S+1} into the program counter low byte and {page, S+2} into the high byte, leaves `st_rest` unchanged, and the pointer ends at S+2.
- R7: The pointer wraps modulo 256 in both directions. The address high byte is the `page` value sampled with `go` and does not follow later changes of `page`.
- R8: Writes of one operation take place on consecutive clocks, one per clock, and `mem_we` is high only while `busy` is high.
- R9: `busy` rises on the clock edge that samples `go` and stays high until the edge that raises `fin`. `fin` is a one-cycle pulse that arrives 4, 3, 5 and 4 cycles after the start edge for codes 00, 01, 10 and 11.
- R10: A `go` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse, taken only when idle |
| op | input | 2 | 00 interrupt entry, 01 call, 10 return from interrupt, 11 return from subroutine |
| sw_brk | input | 1 | Interrupt entry was caused by a software break |
| page | input | 8 | Stack page, used as the address high byte |
| pc_in | input | 16 | Program counter to save |
| st_in | input | 8 | Status byte to save |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| pc_rest | output | 16 | Restored program counter |
| st_rest | output | 8 | Restored status byte |
| sp | output | 8 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| fin | output | 1 | One-cycle completion pulse |

## Verification
The edge that samples `go` only latches the command. The first access is presented one cycle later. A write lands in memory at the edge after it is presented, and read data returns two edges after its address is registered. As a result, `fin` is due 4, 3, 5 and 4 cycles after the start edge for interrupt entry, call, return from interrupt and return from subroutine. The bench counts falling edges from the start edge and requires `fin` at exactly that count. It reads the write log, `pc_rest`, `st_rest` and `sp` only on the falling edge where `fin` is seen. The write log records a cycle stamp for each write, so the check on consecutive writes compares stamps and does not depend on sampling order.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    OP_IRQ  = 2'b00,
    OP_CALL = 2'b01,
    OP_RETI = 2'b10,
    OP_RETS = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SL_PCH = 2'b00,
    SL_PCL = 2'b01,
    SL_ST  = 2'b10
  } slot_e;

  localparam int BRK_POS = 4;

  function automatic logic [1:0] xfer_count(op_e o);
    case (o)
      OP_IRQ, OP_RETI: xfer_count = 2'd3;
      default:         xfer_count = 2'd2;
    endcase
  endfunction

  // order of bytes moved for each operation
  function automatic slot_e slot_at(op_e o, logic [1:0] i);
    slot_e s;
    case (o)
      OP_RETI: s = (i == 2'd0) ? SL_ST : ((i == 2'd1) ? SL_PCL : SL_PCH);
      OP_RETS: s = (i == 2'd0) ? SL_PCL : SL_PCH;
      default: s = (i == 2'd0) ? SL_PCH : ((i == 2'd1) ? SL_PCL : SL_ST);
    endcase
    return s;
  endfunction

  function automatic logic is_pull(op_e o);
    return o[1];
  endfunction

endpackage

// File: rtl/stack_ptr.sv
module stack_ptr #(
  parameter int PTR_W = 8,
  parameter logic [PTR_W-1:0] SP_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [PTR_W-1:0] sp,
  output logic [PTR_W-1:0] sp_up
);

  assign sp_up = sp + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)      sp <= SP_INIT;
    else if (inc) sp <= sp_up;
    else if (dec) sp <= sp - 1'b1;
  end

endmodule

// File: rtl/stack_restore.sv
module stack_restore
  import stack_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cap_en,
  input  slot_e               cap_slot,
  input  logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] pc_rest,
  output logic [DATA_W-1:0]   st_rest
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_rest <= '0;
      st_rest <= '0;
    end else if (cap_en) begin
      case (cap_slot)
        SL_PCH:  pc_rest[DATA_W +: DATA_W] <= rdata;
        SL_PCL:  pc_rest[0 +: DATA_W]      <= rdata;
        default: st_rest                   <= rdata;
      endcase
    end
  end

endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int PG_W   = 8,
  localparam int ADDR_W = PG_W + PTR_W,
  localparam int PC_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [1:0]        op,
  input  logic              sw_brk,
  input  logic [PG_W-1:0]   page,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] st_in,
  input  logic [PTR_W-1:0]  sp,
  input  logic [PTR_W-1:0]  sp_up,
  output logic              ptr_inc,
  output logic              ptr_dec,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              cap_en,
  output slot_e             cap_slot,
  output logic              rd_live,
  output logic              busy,
  output logic              fin
);

  op_e              cur;
  logic [1:0]       idx;
  logic [PG_W-1:0]  pg_l;
  logic [PC_W-1:0]  pc_l;
  logic [DATA_W-1:0] st_l;
  logic             p1_vld, p1_last, p2_vld, p2_last;
  slot_e            p1_slot, p2_slot;

  logic [1:0]       n_xfer;
  logic             issue, pull, last_now;
  slot_e            slot_now;
  logic [DATA_W-1:0] byte_now;

  always_comb begin
    n_xfer   = xfer_count(cur);
    pull     = is_pull(cur);
    issue    = busy && (idx < n_xfer);
    slot_now = slot_at(cur, idx);
    last_now = (idx == n_xfer - 2'd1);
    case (slot_now)
      SL_PCH:  byte_now = pc_l[DATA_W +: DATA_W];
      SL_PCL:  byte_now = pc_l[0 +: DATA_W];
      default: byte_now = st_l;
    endcase
  end

  assign ptr_inc  = issue && pull;
  assign ptr_dec  = issue && !pull;
  assign cap_en   = p2_vld;
  assign cap_slot = p2_slot;
  assign rd_live  = p1_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      fin       <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      idx       <= '0;
      cur       <= OP_IRQ;
      pg_l      <= '0;
      pc_l      <= '0;
      st_l      <= '0;
      p1_vld    <= 1'b0;
      p1_last   <= 1'b0;
      p1_slot   <= SL_PCH;
      p2_vld    <= 1'b0;
      p2_last   <= 1'b0;
      p2_slot   <= SL_PCH;
    end else begin
      fin     <= 1'b0;
      p1_vld  <= issue && pull;
      p1_last <= last_now;
      p1_slot <= slot_now;
      p2_vld  <= p1_vld;
      p2_last <= p1_last;
      p2_slot <= p1_slot;
      if (!busy) begin
        mem_we <= 1'b0;
        if (go) begin
          busy <= 1'b1;
          idx  <= '0;
          cur  <= op_e'(op);
          pg_l <= page;
          pc_l <= pc_in;
          st_l <= st_in;
          st_l[BRK_POS] <= sw_brk;
        end
      end else begin
        mem_we <= issue && !pull;
        if (issue) begin
          mem_addr  <= {pg_l, (pull ? sp_up : sp)};
          mem_wdata <= byte_now;
          idx       <= idx + 2'd1;
        end
        if ((!pull && idx == n_xfer) || (pull && p2_vld && p2_last)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 8,
  parameter int PG_W   = 8,
  parameter logic [PTR_W-1:0] SP_INIT = '1,
  localparam int ADDR_W = PG_W + PTR_W,
  localparam int PC_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [1:0]        op,
  input  logic              sw_brk,
  input  logic [PG_W-1:0]   page,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [DATA_W-1:0] st_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PC_W-1:0]   pc_rest,
  output logic [DATA_W-1:0] st_rest,
  output logic [PTR_W-1:0]  sp,
  output logic              busy,
  output logic              fin
);

  logic             ptr_inc, ptr_dec, cap_en, rd_live;
  logic [PTR_W-1:0] sp_up;
  slot_e            cap_slot;

  stack_ptr #(.PTR_W(PTR_W), .SP_INIT(SP_INIT)) u_ptr (
    .clk(clk), .rst(rst), .inc(ptr_inc), .dec(ptr_dec),
    .sp(sp), .sp_up(sp_up)
  );

  stack_ctrl #(.DATA_W(DATA_W), .PTR_W(PTR_W), .PG_W(PG_W)) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .op(op), .sw_brk(sw_brk),
    .page(page), .pc_in(pc_in), .st_in(st_in),
    .sp(sp), .sp_up(sp_up), .ptr_inc(ptr_inc), .ptr_dec(ptr_dec),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .cap_en(cap_en), .cap_slot(cap_slot), .rd_live(rd_live),
    .busy(busy), .fin(fin)
  );

  stack_restore #(.DATA_W(DATA_W)) u_rest (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cap_slot(cap_slot),
    .rdata(mem_rdata), .pc_rest(pc_rest), .st_rest(st_rest)
  );

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              go,
  input logic              busy,
  input logic              fin,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PTR_W-1:0]  sp,
  input logic              rd_live
);

  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R9
  fin_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);

  // R9
  fin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> !busy);

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> $stable(mem_addr[ADDR_W-1:PTR_W]));

  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (sp == PTR_W'(mem_addr[PTR_W-1:0] - 1'b1)));

  // R5
  pull_inc_chk: assert property (@(posedge clk) disable iff (rst)
    rd_live |-> (sp == mem_addr[PTR_W-1:0]));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));

endmodule

bind stack_seq stack_seq_chk #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .go(go), .busy(busy), .fin(fin),
  .mem_we(mem_we), .mem_addr(mem_addr), .sp(sp), .rd_live(rd_live)
);

// File: tb/stack_seq_test.sv
module stack_seq_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        go = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        sw_brk = 1'b0;
  logic [7:0]  page = 8'h00;
  logic [15:0] pc_in = 16'h0;
  logic [7:0]  st_in = 8'h0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [7:0]  mem_rdata = 8'h00;
  logic [15:0] pc_rest;
  logic [7:0]  st_rest;
  logic [7:0]  sp;
  logic        busy, fin;

  stack_seq uut (
    .clk(clk), .rst(rst), .go(go), .op(op), .sw_brk(sw_brk), .page(page),
    .pc_in(pc_in), .st_in(st_in), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .pc_rest(pc_rest),
    .st_rest(st_rest), .sp(sp), .busy(busy), .fin(fin)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [7:0]  bmem [256];
  logic [15:0] log_a [64];
  logic [7:0]  log_d [64];
  int          log_c [64];
  int          nlog = 0;
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  int          base;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= bmem[mem_addr[7:0]];
    if (mem_we && nlog < 64) begin
      log_a[nlog] <= mem_addr;
      log_d[nlog] <= mem_wdata;
      log_c[nlog] <= cyc;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_wr(input int i, input logic [15:0] a, input logic [7:0] d,
                        input string req);
    chk(log_a[base+i] == a, {req, " addr"}, 32'(log_a[base+i]), 32'(a));
    chk(log_d[base+i] == d, {req, " data"}, 32'(log_d[base+i]), 32'(d));
  endtask

  // runs one operation; R9 timing, R8 write spacing, R7 page latch
  task automatic run_op(input logic [1:0] c, input logic b, input logic [15:0] pcv,
                        input logic [7:0] stv, input logic [7:0] pgv,
                        input int exp_lat, input bit poke);
    int lat;
    int gap;
    base = nlog;
    @(negedge clk);
    op = c; sw_brk = b; pc_in = pcv; st_in = stv; page = pgv; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    page = ~pgv;
    chk(busy == 1'b1, "R9 busy after start", 32'(busy), 1);
    lat = 0;
    gap = 0;
    while (!fin && lat < 20) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 1) begin go = 1'b1; op = 2'b01; end
      else go = 1'b0;
      if (!fin && !busy) gap++;
    end
    go = 1'b0;
    chk(lat == exp_lat, "R9 fin latency", 32'(lat), 32'(exp_lat));
    chk(gap == 0, "R9 busy gap", 32'(gap), 0);
    chk(busy == 1'b0, "R9 busy at fin", 32'(busy), 0);
    for (int i = 1; i < nlog - base; i++)
      chk(log_c[base+i] == log_c[base+i-1] + 1, "R8 consecutive writes",
          32'(log_c[base+i]), 32'(log_c[base+i-1] + 1));
  endtask

  task automatic t_reset;
    chk(sp == 8'hFF, "R1 sp", 32'(sp), 32'hFF);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(fin == 1'b0, "R1 fin", 32'(fin), 0);
    chk(mem_we == 1'b0, "R1 we", 32'(mem_we), 0);
    chk(pc_rest == 16'h0 && st_rest == 8'h0, "R1 restore regs",
        {8'h0, st_rest, pc_rest}, 0);
  endtask

  task automatic t_rets_wrap;
    run_op(2'b11, 1'b0, 16'h0, 8'h0, 8'h03, 4, 1'b0);
    chk(nlog == base, "R6 no writes", 32'(nlog - base), 0);
    chk(pc_rest == 16'h5678, "R6 pc", 32'(pc_rest), 32'h5678);
    chk(st_rest == 8'h00, "R6 status untouched", 32'(st_rest), 0);
    chk(sp == 8'h01, "R7 sp wrap up", 32'(sp), 32'h01);
  endtask

  task automatic t_irq_wrap;
    run_op(2'b00, 1'b0, 16'h1234, 8'hA5, 8'h03, 4, 1'b0);
    chk(nlog - base == 3, "R2 write count", 32'(nlog - base), 3);
    chk_wr(0, 16'h0301, 8'h12, "R2 pch");
    chk_wr(1, 16'h0300, 8'h34, "R2 pcl");
    chk_wr(2, 16'h03FF, 8'hA5, "R7 status wrapped");
    chk(sp == 8'hFE, "R7 sp wrap down", 32'(sp), 32'hFE);
  endtask

  task automatic t_reti;
    run_op(2'b10, 1'b0, 16'h0, 8'h0, 8'h03, 5, 1'b0);
    chk(nlog == base, "R5 no writes", 32'(nlog - base), 0);
    chk(st_rest == 8'hA5, "R5 status", 32'(st_rest), 32'hA5);
    chk(pc_rest == 16'h1234, "R5 pc", 32'(pc_rest), 32'h1234);
    chk(sp == 8'h01, "R5 sp", 32'(sp), 32'h01);
  endtask

  task automatic t_brk;
    run_op(2'b00, 1'b0, 16'h0102, 8'h5A, 8'h03, 4, 1'b0);
    chk_wr(2, 16'h03FF, 8'h4A, "R3 non-break clears bit 4");
    run_op(2'b00, 1'b1, 16'h0304, 8'h00, 8'h03, 4, 1'b0);
    chk_wr(2, 16'h03FC, 8'h10, "R3 break sets bit 4");
    chk(sp == 8'hFB, "R3 sp", 32'(sp), 32'hFB);
  endtask

  task automatic t_call_ret;
    run_op(2'b01, 1'b0, 16'hABCD, 8'hFF, 8'h02, 3, 1'b0);
    chk(nlog - base == 2, "R4 write count", 32'(nlog - base), 2);
    chk_wr(0, 16'h02FB, 8'hAB, "R4 pch");
    chk_wr(1, 16'h02FA, 8'hCD, "R4 pcl");
    chk(sp == 8'hF9, "R4 sp", 32'(sp), 32'hF9);
    run_op(2'b11, 1'b0, 16'h0, 8'h0, 8'h02, 4, 1'b0);
    chk(pc_rest == 16'hABCD, "R6 pc", 32'(pc_rest), 32'hABCD);
    chk(st_rest == 8'hA5, "R6 status kept", 32'(st_rest), 32'hA5);
    chk(sp == 8'hFB, "R6 sp", 32'(sp), 32'hFB);
  endtask

  task automatic t_ignore;
    run_op(2'b00, 1'b0, 16'h0F0E, 8'h00, 8'h01, 4, 1'b1);
    repeat (3) @(negedge clk);
    chk(nlog - base == 3, "R10 writes", 32'(nlog - base), 3);
    chk_wr(2, 16'h01F9, 8'h00, "R10 last write");
    chk(busy == 1'b0, "R10 stays idle", 32'(busy), 0);
    chk(sp == 8'hF8, "R10 sp", 32'(sp), 32'hF8);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
    bmem[0] = 8'h78;
    bmem[1] = 8'h56;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_rets_wrap();
    t_irq_wrap();
    t_reti();
    t_brk();
    t_call_ret();
    t_ignore();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog act=%0d exp=<5000", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule